// File: doc/BRIEF.md
# Dual-Clock Interval Timer

A 16-bit interval timer whose counter runs on its own timer clock, which may be unrelated to and far slower than the bus clock (a 10 MHz bus against a 32 kHz timer clock is a supported ratio). The bus side offers a simple write channel and a combinational read port over four locations: a reload value, the current count, a control word and an interrupt-clear location. Every write crosses into the timer domain through a toggle request and acknowledge handshake. The count returns to the bus side as a stable snapshot over a second, free-cycling handshake, so a read never returns a half-updated value.

The counter runs up or down, in free-running mode (it starts from the reload value and then wraps to the opposite extreme) or in periodic mode (it reloads from the reload value at every terminal count). A timer-clock divider of 1, 16, 256 or 32768 sets the tick rate. A terminal count sets a level interrupt flag in the timer domain. The flag is resynchronised onto `irq` and stays set until software writes the clear location.

The write channel is valid/ready. `wr_ready` is low from the cycle after a write is accepted until its acknowledge has returned. A master holding `wr_valid` keeps `wr_addr` and `wr_data` steady, and its write is taken on the first cycle `wr_ready` is high. Reads never stall.

Top module: `dct_timer`

## Requirements
- R1: After reset the count location reads 0, the status location reads 0, `irq` is 0 and `wr_ready` is 1.
- R2: On a tick where the counter already holds its terminal value (0 counting down, all ones counting up), the interrupt flag is set and `irq` follows it two bus-clock edges later.
- R3: A write of any data to address 3 clears the interrupt flag in the timer domain, and `irq` falls after the clear has crossed.
- R4: In free-running mode a tick at the terminal value moves a down-counter to all ones and an up-counter to 0. The reload value is not used.
- R5: In periodic mode a tick at the terminal value reloads the counter from the reload register.
- R6: Address 1 returns a snapshot of the count taken on one of the last few timer-clock edges, and the snapshot never changes while it is being captured.
- R7: Control bits [4:3] select a tick on every 1st (0), 16th (1), 256th (2) or 32768th (3) timer-clock edge. The divider restarts on each control write, so the first tick falls that many edges after the edge that applies the write.
- R8: After a write is accepted, `wr_ready` is low the next cycle and stays low until the acknowledge returns. A write offered while it is low is not taken, and the bus-side shadow registers do not change.
- R9: Control bit 0 enables, bit 1 selects up counting (1) or down counting (0), and bit 2 selects periodic (1) or free-running (0). A write takes effect on the third timer-clock rising edge after it is accepted. On that edge a control write with bit 0 set loads the counter from the reload register, and one with bit 0 clear freezes it.
- R10: When a clear and a terminal-count tick fall on the same timer edge, the flag stays set. A reload value of 0 in periodic down mode gives a terminal count on every tick.
- R11: Address 0 reads the last accepted reload value, address 2 the last accepted control word (bits [4:0]), and address 3 the status word with bit 1 = write pending and bit 0 = `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| tmr_clk | input | 1 | Timer clock, asynchronous to bus_clk |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write channel can accept |
| wr_addr | input | 2 | Write address: 0 reload, 2 control, 3 clear |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data, combinational from bus-side registers |
| irq | output | 1 | Level interrupt, bus domain |

## Verification
The hardest case to reach from the ports is a clear that lands on exactly the timer edge where a terminal-count tick also sets the flag. Its timing hangs on a three-edge crossing that the bench cannot see directly. The stimulus removes the alignment problem by using a reload value of 0 in periodic down mode, where every tick is terminal, so any clear must collide. It then repeats the clear with the divider at 16, where the clear lands between ticks and must win. The bench owns the timer clock and pulses it one edge at a time with long gaps, so each crossing completes between edges and the reference model can follow every edge.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 5;
  localparam int PRE_W  = 15;

  localparam logic [ADDR_W-1:0] A_LOAD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR = 2'd3;

  // bit 0 enable, bit 1 up, bit 2 periodic, bits 4:3 divider select
  typedef struct packed {
    logic [1:0] div;
    logic       periodic;
    logic       up;
    logic       en;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return '0;
      2'd1:    return PRE_W'(15);
      2'd2:    return PRE_W'(255);
      default: return PRE_W'(32767);
    endcase
  endfunction
endpackage

// File: rtl/dct_sync_bit.sv
module dct_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/dct_wr_xfer.sv
module dct_wr_xfer
  import dct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              tmr_clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              t_apply,
  output logic [ADDR_W-1:0] t_addr,
  output logic [DATA_W-1:0] t_data
);
  logic              req_q;
  logic              ack_b;
  logic              req_t;
  logic              ack_t;
  logic [ADDR_W-1:0] hold_a;
  logic [DATA_W-1:0] hold_d;

  assign busy     = req_q ^ ack_b;
  assign in_ready = ~busy;

  // bus side: capture the write and flip the request
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      hold_a <= '0;
      hold_d <= '0;
    end else if (in_valid && in_ready) begin
      req_q  <= ~req_q;
      hold_a <= in_addr;
      hold_d <= in_data;
    end
  end

  dct_sync_bit #(.STAGES(STAGES)) u_req_sync (
    .clk(tmr_clk), .rst_n(rst_n), .d(req_q), .q(req_t)
  );

  // timer side: a request level differing from the acknowledge is one write
  assign t_apply = req_t ^ ack_t;

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n)       ack_t <= 1'b0;
    else if (t_apply) ack_t <= req_t;
  end

  dct_sync_bit #(.STAGES(STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(ack_t), .q(ack_b)
  );

  // held words stay still until the acknowledge returns
  assign t_addr = hold_a;
  assign t_data = hold_d;
endmodule

// File: rtl/dct_snap_xfer.sv
module dct_snap_xfer #(
  parameter int DATA_W = 16,
  parameter int STAGES = 2
) (
  input  logic              tmr_clk,
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] t_val,
  output logic [DATA_W-1:0] b_val
);
  logic              tog_q;
  logic              ack_q;
  logic              tog_b;
  logic              ack_t;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] val_q;

  // timer side: take a new snapshot once the previous one is acknowledged
  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      snap_q <= '0;
    end else if (ack_t == tog_q) begin
      tog_q  <= ~tog_q;
      snap_q <= t_val;
    end
  end

  dct_sync_bit #(.STAGES(STAGES)) u_tog_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(tog_q), .q(tog_b)
  );

  // bus side: copy the frozen snapshot, then acknowledge
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      val_q <= '0;
    end else if (tog_b != ack_q) begin
      ack_q <= tog_b;
      val_q <= snap_q;
    end
  end

  dct_sync_bit #(.STAGES(STAGES)) u_ack_sync (
    .clk(tmr_clk), .rst_n(rst_n), .d(ack_q), .q(ack_t)
  );

  assign b_val = val_q;
endmodule

// File: rtl/dct_core.sv
module dct_core
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              tmr_clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  data,
  output logic [CNT_W-1:0]  cnt,
  output logic              flag
);
  localparam logic [CNT_W-1:0] TOP_VAL = '1;

  ctrl_t             ctrl_q;
  ctrl_t             new_ctrl;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [PRE_W-1:0]  pre_q;
  logic              flag_q;
  logic              wr_ctrl;
  logic              wr_load;
  logic              wr_clr;
  logic              pre_hit;
  logic              tick;
  logic              at_end;

  assign wr_ctrl  = apply && (addr == A_CTRL);
  assign wr_load  = apply && (addr == A_LOAD);
  assign wr_clr   = apply && (addr == A_CLEAR);
  assign new_ctrl = ctrl_t'(data[CTRL_W-1:0]);

  assign pre_hit = (pre_q == pre_limit(ctrl_q.div));
  assign tick    = ctrl_q.en && !wr_ctrl && pre_hit;
  assign at_end  = ctrl_q.up ? (cnt_q == TOP_VAL) : (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ctrl) begin
      if (new_ctrl.en) cnt_d = load_q;
    end else if (tick) begin
      if (at_end)
        cnt_d = ctrl_q.periodic ? load_q : (ctrl_q.up ? '0 : TOP_VAL);
      else
        cnt_d = ctrl_q.up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_ctrl)      ctrl_q <= new_ctrl;
      if (wr_load)      load_q <= data;
      if (wr_ctrl)      pre_q  <= '0;
      else if (ctrl_q.en) pre_q <= pre_hit ? '0 : pre_q + PRE_W'(1);
      // a terminal tick beats a clear on the same edge
      if (tick && at_end) flag_q <= 1'b1;
      else if (wr_clr)    flag_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              tmr_clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  logic              busy;
  logic              t_apply;
  logic [ADDR_W-1:0] t_addr;
  logic [CNT_W-1:0]  t_data;
  logic [CNT_W-1:0]  cnt_t;
  logic [CNT_W-1:0]  cnt_b;
  logic              flag_t;
  logic [CNT_W-1:0]  load_sh;
  logic [CTRL_W-1:0] ctrl_sh;

  dct_wr_xfer #(.DATA_W(CNT_W), .STAGES(SYNC_STAGES)) u_wr (
    .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
    .in_valid(wr_valid), .in_ready(wr_ready),
    .in_addr(wr_addr), .in_data(wr_data), .busy(busy),
    .t_apply(t_apply), .t_addr(t_addr), .t_data(t_data)
  );

  dct_core #(.CNT_W(CNT_W)) u_core (
    .tmr_clk(tmr_clk), .rst_n(rst_n), .apply(t_apply),
    .addr(t_addr), .data(t_data), .cnt(cnt_t), .flag(flag_t)
  );

  dct_snap_xfer #(.DATA_W(CNT_W), .STAGES(SYNC_STAGES)) u_snap (
    .tmr_clk(tmr_clk), .bus_clk(bus_clk), .rst_n(rst_n),
    .t_val(cnt_t), .b_val(cnt_b)
  );

  dct_sync_bit #(.STAGES(SYNC_STAGES)) u_irq_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(flag_t), .q(irq)
  );

  // bus-side shadows of accepted writes
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      load_sh <= '0;
      ctrl_sh <= '0;
    end else if (wr_valid && wr_ready) begin
      if (wr_addr == A_LOAD) load_sh <= wr_data;
      if (wr_addr == A_CTRL) ctrl_sh <= wr_data[CTRL_W-1:0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_LOAD:  rd_data = load_sh;
      A_COUNT: rd_data = cnt_b;
      A_CTRL:  rd_data = CNT_W'(ctrl_sh);
      default: rd_data = CNT_W'({busy, irq});
    endcase
  end
endmodule

// File: rtl/dct_timer_chk.sv
module dct_timer_chk
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              bus_clk,
  input logic              tmr_clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              busy,
  input logic              t_apply,
  input logic [ADDR_W-1:0] t_addr,
  input logic [CNT_W-1:0]  t_data,
  input logic [CNT_W-1:0]  cnt_t,
  input logic              flag_t
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  assert_accept_busy_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> busy);

  assert_hold_stable_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    busy |=> ($stable(t_addr) && $stable(t_data)));

  assert_flag_at_terminal_R2: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    $rose(flag_t) |-> ($past(cnt_t) == '0 || $past(cnt_t) == ALL_ONES));

  assert_flag_drop_by_clear_R3: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    $fell(flag_t) |-> $past(t_apply && t_addr == A_CLEAR));

  assert_stop_holds_R9: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    $past(t_apply && t_addr == A_CTRL && !t_data[0]) |-> $stable(cnt_t));
endmodule

bind dct_timer dct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy),
  .t_apply(t_apply), .t_addr(t_addr), .t_data(t_data),
  .cnt_t(cnt_t), .flag_t(flag_t)
);

// File: tb/dct_timer_bench.sv
module dct_timer_bench;
  localparam int W   = 16;
  localparam int GAP = 12;

  logic         bus_clk = 1'b0;
  logic         tmr_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         wr_valid = 1'b0;
  logic [1:0]   wr_addr  = '0;
  logic [W-1:0] wr_data  = '0;
  logic [1:0]   rd_addr  = '0;
  logic         wr_ready;
  logic [W-1:0] rd_data;
  logic         irq;

  always #5 bus_clk = ~bus_clk;

  dct_timer u_dct_timer (
    .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference model, advanced once per timer edge
  typedef struct { int addr; int data; int age; } pend_t;
  pend_t pq[$];
  int    hist[$];
  int    m_load = 0, m_cnt = 0, m_pre = 0, m_div = 0;
  bit    m_en = 0, m_up = 0, m_per = 0, m_flag = 0;
  bit    acc_mark = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ctl(bit en, bit up, bit per, int div);
    return int'(en) | (int'(up) << 1) | (int'(per) << 2) | (div << 3);
  endfunction

  task automatic model_edge();
    bit ap = 0; int aa = 0, ad = 0, lim, ncnt, npre;
    bit wc, wl, wk, tk, ae, nflag;
    foreach (pq[i]) pq[i].age++;
    if (pq.size() > 0 && pq[0].age >= 3) begin
      ap = 1; aa = pq[0].addr; ad = pq[0].data;
      void'(pq.pop_front());
    end
    wc = ap && aa == 2; wl = ap && aa == 0; wk = ap && aa == 3;
    lim = (m_div == 0) ? 0 : (m_div == 1) ? 15 : (m_div == 2) ? 255 : 32767;
    tk = m_en && !wc && (m_pre == lim);
    ae = m_up ? (m_cnt == 16'hFFFF) : (m_cnt == 0);
    ncnt = m_cnt;
    if (wc) begin
      if (ad[0]) ncnt = m_load;
    end else if (tk) begin
      if (ae) ncnt = m_per ? m_load : (m_up ? 0 : 16'hFFFF);
      else    ncnt = m_up ? ((m_cnt + 1) & 16'hFFFF) : ((m_cnt - 1) & 16'hFFFF);
    end
    npre = wc ? 0 : (m_en ? ((m_pre == lim) ? 0 : m_pre + 1) : m_pre);
    nflag = (tk && ae) ? 1'b1 : (wk ? 1'b0 : m_flag);
    if (wl) m_load = ad & 16'hFFFF;
    if (wc) begin
      m_en = ad[0]; m_up = ad[1]; m_per = ad[2]; m_div = (ad >> 3) & 3;
    end
    m_cnt = ncnt; m_pre = npre; m_flag = nflag;
    hist.push_back(m_cnt);
    if (hist.size() > 5) void'(hist.pop_front());
  endtask

  // one bus cycle; tracks acceptance of a pending write
  task automatic step();
    @(negedge bus_clk);
    if (acc_mark) begin
      wr_valid = 1'b0; acc_mark = 0;
    end else if (wr_valid && wr_ready) begin
      pq.push_back('{int'(wr_addr), int'(wr_data), 0});
      acc_mark = 1;
    end
  endtask

  task automatic tpulse();
    step();
    #7 tmr_clk = 1'b1;
    model_edge();
    step(); step();
    tmr_clk = 1'b0;
    repeat (GAP) step();
    chk(irq == m_flag, "R2", "irq per timer edge", int'(irq), int'(m_flag));
  endtask

  task automatic bwrite(input int a, input int d);
    while (wr_valid) tpulse();
    wr_addr = a[1:0]; wr_data = d[W-1:0]; wr_valid = 1'b1;
    if (wr_ready) begin
      pq.push_back('{a, d, 0});
      acc_mark = 1;
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[1:0];
    #1 v = int'(rd_data);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) tpulse();
  endtask

  task automatic freeze_check(input string req);
    int v;
    bwrite(2, 0);
    pulses(7);
    rd(1, v);
    chk(v == m_cnt, req, "frozen count", v, m_cnt);
  endtask

  task automatic live_check(input string req);
    int v; bit hit = 0;
    rd(1, v);
    foreach (hist[i]) if (hist[i] == v) hit = 1;
    chk(hit, req, "live count within recent edges", v, m_cnt);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge bus_clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int v;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    rd(1, v); chk(v == 0, "R1", "count after reset", v, 0);
    rd(3, v); chk(v == 0, "R1", "status after reset", v, 0);
    chk(wr_ready == 1'b1, "R1", "ready after reset", int'(wr_ready), 1);
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);

    // periodic down from 4
    bwrite(0, 4); pulses(4);
    rd(0, v); chk(v == 4, "R11", "reload shadow", v, 4);
    bwrite(2, ctl(1, 0, 1, 0)); step();
    rd(2, v); chk(v == 5, "R11", "control shadow", v, 5);
    pulses(14);
    chk(irq == 1'b1, "R2", "irq after terminal count down", int'(irq), 1);
    rd(3, v); chk(v == 1, "R11", "status shows irq", v, 1);
    live_check("R6");
    freeze_check("R5");
    pulses(10);
    rd(1, v); chk(v == m_cnt, "R9", "count stays frozen", v, m_cnt);

    // clear with arbitrary data
    bwrite(3, 16'hBEEF); pulses(4);
    chk(irq == 1'b0, "R3", "irq after clear with data BEEF", int'(irq), 0);

    // free-running down from 2 wraps to all ones
    bwrite(0, 2); bwrite(2, ctl(1, 0, 0, 0)); pulses(9);
    freeze_check("R4");
    bwrite(3, 0); pulses(4);
    chk(irq == 1'b0, "R3", "irq after clear with data 0", int'(irq), 0);

    // periodic up from FFFD
    bwrite(0, 16'hFFFD); bwrite(2, ctl(1, 1, 1, 0)); pulses(10);
    live_check("R6");
    freeze_check("R5");
    bwrite(3, 16'h5A5A); pulses(4);

    // free-running up from FFFE wraps to 0
    bwrite(0, 16'hFFFE); bwrite(2, ctl(1, 1, 0, 0)); pulses(8);
    freeze_check("R4");
    bwrite(3, 1); pulses(4);

    // divider by 16 and by 256
    bwrite(0, 100); bwrite(2, ctl(1, 0, 1, 1)); pulses(60);
    live_check("R7");
    freeze_check("R7");
    bwrite(0, 0); bwrite(2, ctl(1, 1, 0, 2)); pulses(560);
    freeze_check("R7");

    // back-pressure
    bwrite(0, 7); step();
    chk(wr_ready == 1'b0, "R8", "ready low after accept", int'(wr_ready), 0);
    rd(3, v); chk(((v >> 1) & 1) == 1, "R11", "status pending bit", v, 2);
    bwrite(2, 16'h001D);
    repeat (5) step();
    rd(2, v); chk(v == 0, "R8", "held write not taken while busy", v, 0);
    rd(0, v); chk(v == 7, "R8", "first write taken", v, 7);
    pulses(8);
    rd(2, v); chk(v == 16'h1D, "R8", "held write taken after ack", v, 16'h1D);
    freeze_check("R9");

    // collision of clear and terminal tick
    bwrite(0, 0); bwrite(2, ctl(1, 0, 1, 0)); pulses(6);
    chk(irq == 1'b1, "R10", "zero reload sets flag", int'(irq), 1);
    bwrite(3, 16'hFFFF); pulses(4);
    chk(irq == 1'b1, "R10", "terminal tick beats clear", int'(irq), 1);
    bwrite(2, ctl(1, 0, 1, 1)); pulses(2);
    bwrite(3, 16'h0042); pulses(4);
    chk(irq == 1'b0, "R3", "clear between divided ticks", int'(irq), 0);
    pulses(16);
    chk(irq == 1'b1, "R10", "flag set again on next divided tick", int'(irq), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule